// File: doc/BRIEF.md
# Page-Mapping Memory Management Unit

This unit sits between a CPU with a 16-bit logical address and a 1 MB physical memory. It splits the address space into sixteen 4 KB pages. The top four logical bits pick one entry in a small mapping table. That entry supplies the eight upper physical bits. The twelve offset bits pass through untouched. The translation path is combinational, so a physical address is ready in the same cycle as the logical one.

Translation is off after reset. While it is off, the unit forces all upper physical bits high. Every logical page therefore lands in the highest 4 KB frame, which is where boot ROM is expected to sit. Boot code fills the table through a small register port while translation is off, then sets the enable bit. The usual practice is to keep logical page 0 mapped to the top frame, so the running boot code stays in place once translation is on.

The register port has a write strobe and a select bit. The select bit chooses between a table entry, named by an index, and the control register. A registered read-back path returns either the chosen entry or the enable state.

Top module: `pgmap_mmu`

## Requirements
- R1: While reset is held and in the first cycle after it, `xlate_on` is 0, `phys_addr[19:12]` is 8'hFF, and a control read-back returns 8'h00.
- R2: `phys_addr[11:0]` always equals `log_addr[11:0]`, whether translation is on or off.
- R3: While translation is off, `phys_addr[19:12]` is 8'hFF for every logical address.
- R4: A strobe with `cfg_sel`=0 stores `cfg_wdata` in table entry `cfg_idx`. A strobe with `cfg_sel`=1 loads the enable from `cfg_wdata` bit 0. Bits 7:1 of a control write are ignored.
- R5: While translation is on, `phys_addr[19:12]` equals the entry indexed by `log_addr[15:12]`.
- R6: A table or control write first affects translation in the cycle after its strobe. In the strobe cycle itself, the output still shows the old entry or the old enable.
- R7: `cfg_rdata` is registered. It shows the value selected by `cfg_sel`/`cfg_idx` one cycle earlier, taken before any write in that cycle. The control register reads as {7'b0, enable}.
- R8: Turning translation off and on again leaves all table entries unchanged. The mapping seen before the off period returns.
- R9: `xlate_on` shows the enable state, and it changes only after a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = table entry, 1 = control register |
| cfg_idx | input | 4 | Table entry index |
| cfg_wdata | input | 8 | Write data (frame number, or enable in bit 0) |
| cfg_rdata | output | 8 | Registered read-back data |
| log_addr | input | 16 | CPU logical address |
| phys_addr | output | 20 | Translated physical address |
| xlate_on | output | 1 | Translation enable state |

## Verification
Two functions can fall in the same cycle: a register write and a translation that uses the register being written. The bench provokes this by strobing a new frame into entry 5 while the logical address points into page 5. It also writes the enable bit while a translated page is being addressed. In both cases the output sampled during the strobe cycle must show the old mapping, and the output one cycle later must show the new one. The read-back sampled after that strobe must show the entry's value from before the write.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  // Register port target select
  typedef enum logic {
    SEL_PAGE = 1'b0,
    SEL_CTRL = 1'b1
  } cfg_target_e;

  // Bit of the control word that holds the translation enable
  localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/pgmap_table.sv
// Page-frame table: one synchronous write port, two asynchronous read ports.
module pgmap_table #(
  parameter int IDX_W = 4,
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [FRM_W-1:0] wdata,
  input  logic [IDX_W-1:0] lidx,
  output logic [FRM_W-1:0] lfrm,
  input  logic [IDX_W-1:0] ridx,
  output logic [FRM_W-1:0] rfrm
);
  localparam int N_PAGES = 1 << IDX_W;

  logic [FRM_W-1:0] mem [N_PAGES];

  // No reset on the storage: contents are undefined until software loads them
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign lfrm = mem[lidx];
  assign rfrm = mem[ridx];
endmodule

// File: rtl/pgmap_ctrl.sv
// Enable register and registered read-back mux.
module pgmap_ctrl #(
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             en_bit,
  input  logic             rd_ctrl,
  input  logic [FRM_W-1:0] rfrm,
  output logic             en,
  output logic [FRM_W-1:0] rdata
);
  logic [FRM_W-1:0] ctrl_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[pgmap_pkg::CTRL_EN_BIT] = en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
    end else if (ctrl_we) begin
      en <= en_bit;
    end
  end

  // Read-first: captures the state before any write made in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_ctrl ? ctrl_word : rfrm;
    end
  end
endmodule

// File: rtl/pgmap_xlate.sv
// Combinational address translation.
module pgmap_xlate #(
  parameter int LA_W = 16,
  parameter int PA_W = 20,
  parameter int PG_W = 12
) (
  input  logic                 en,
  input  logic [LA_W-1:0]      log_addr,
  input  logic [PA_W-PG_W-1:0] frame,
  output logic [PA_W-1:0]      phys_addr
);
  localparam int FRM_W = PA_W - PG_W;

  logic [FRM_W-1:0] upper;

  // When off, all upper bits go high: every access hits the top frame
  assign upper     = en ? frame : {FRM_W{1'b1}};
  assign phys_addr = {upper, log_addr[PG_W-1:0]};
endmodule

// File: rtl/pgmap_mmu.sv
module pgmap_mmu #(
  parameter int LA_W = 16,
  parameter int PA_W = 20,
  parameter int PG_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [LA_W-PG_W-1:0]   cfg_idx,
  input  logic [PA_W-PG_W-1:0]   cfg_wdata,
  output logic [PA_W-PG_W-1:0]   cfg_rdata,
  input  logic [LA_W-1:0]        log_addr,
  output logic [PA_W-1:0]        phys_addr,
  output logic                   xlate_on
);
  import pgmap_pkg::*;

  localparam int IDX_W = LA_W - PG_W;
  localparam int FRM_W = PA_W - PG_W;

  logic             is_ctrl;
  logic             tbl_we;
  logic             ctl_we;
  logic [FRM_W-1:0] lfrm;
  logic [FRM_W-1:0] rfrm;
  logic             en;

  assign is_ctrl = (cfg_sel == SEL_CTRL);
  assign tbl_we  = cfg_we && !is_ctrl;
  assign ctl_we  = cfg_we && is_ctrl;

  pgmap_table #(.IDX_W(IDX_W), .FRM_W(FRM_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .widx  (cfg_idx),
    .wdata (cfg_wdata),
    .lidx  (log_addr[LA_W-1:PG_W]),
    .lfrm  (lfrm),
    .ridx  (cfg_idx),
    .rfrm  (rfrm)
  );

  pgmap_ctrl #(.FRM_W(FRM_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (ctl_we),
    .en_bit  (cfg_wdata[CTRL_EN_BIT]),
    .rd_ctrl (is_ctrl),
    .rfrm    (rfrm),
    .en      (en),
    .rdata   (cfg_rdata)
  );

  pgmap_xlate #(.LA_W(LA_W), .PA_W(PA_W), .PG_W(PG_W)) u_xlate (
    .en        (en),
    .log_addr  (log_addr),
    .frame     (lfrm),
    .phys_addr (phys_addr)
  );

  assign xlate_on = en;
endmodule

// File: rtl/pgmap_mmu_chk.sv
module pgmap_mmu_chk #(
  parameter int LA_W = 16,
  parameter int PA_W = 20,
  parameter int PG_W = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic                 cfg_sel,
  input logic [PA_W-PG_W-1:0] cfg_wdata,
  input logic [PA_W-PG_W-1:0] cfg_rdata,
  input logic [LA_W-1:0]      log_addr,
  input logic [PA_W-1:0]      phys_addr,
  input logic                 xlate_on
);
  localparam int FRM_W = PA_W - PG_W;

  p_reset_off_r1: assert property (@(posedge clk) rst |=> !xlate_on);

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    phys_addr[PG_W-1:0] == log_addr[PG_W-1:0]);

  p_off_top_r3: assert property (@(posedge clk) disable iff (rst)
    !xlate_on |-> phys_addr[PA_W-1:PG_W] == {FRM_W{1'b1}});

  p_ctrl_write_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel) |=> xlate_on == $past(cfg_wdata[0]));

  p_ctrl_read_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_sel |=> cfg_rdata == {{(FRM_W-1){1'b0}}, $past(xlate_on)});

  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel) |=> $stable(xlate_on));
endmodule

bind pgmap_mmu pgmap_mmu_chk #(.LA_W(LA_W), .PA_W(PA_W), .PG_W(PG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .log_addr  (log_addr),
  .phys_addr (phys_addr),
  .xlate_on  (xlate_on)
);

// File: tb/tb_pgmap_mmu.sv
`timescale 1ns/1ps
module tb_pgmap_mmu;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] log_addr = '0;
  logic [19:0] phys_addr;
  logic        xlate_on;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(HALF) clk = ~clk;

  pgmap_mmu dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .log_addr(log_addr), .phys_addr(phys_addr), .xlate_on(xlate_on)
  );

  function automatic logic [7:0] frame_of(int i);
    return (i == 0) ? 8'hFF : 8'(8'h20 + i * 13);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(bit sel, int idx, logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(bit sel, int idx, output logic [7:0] val);
    @(negedge clk);
    cfg_sel = sel; cfg_idx = 4'(idx);
    @(negedge clk);
    #1 val = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    log_addr = 16'h3123;
    #1;
    check("R1", 32'(xlate_on), 32'd0, "enable during reset");
    check("R1", 32'(phys_addr), 32'hFF123, "phys during reset");
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1", 32'(xlate_on), 32'd0, "enable after reset");
    reg_read(1'b1, 0, v);
    check("R1", 32'(v), 32'h00, "control readback after reset");
  endtask

  task automatic t_off_sweep();
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      log_addr = 16'((p << 12) | ((p * 291) & 16'hFFF));
      #1;
      check("R3", 32'(phys_addr[19:12]), 32'hFF, "top frame while off");
      check("R2", 32'(phys_addr[11:0]), 32'(log_addr[11:0]), "offset while off");
    end
  endtask

  task automatic t_load_and_enable();
    for (int i = 0; i < 16; i++) reg_write(1'b0, i, frame_of(i));
    @(negedge clk); log_addr = 16'h7456; #1;
    check("R3", 32'(phys_addr[19:12]), 32'hFF, "still off after loading");
    reg_write(1'b1, 0, 8'h01);
    #1 check("R9", 32'(xlate_on), 32'd1, "enable set");
  endtask

  task automatic t_map_sweep(string req);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      log_addr = 16'((p << 12) | ((p * 173 + 5) & 16'hFFF));
      #1;
      check(req, 32'(phys_addr[19:12]), 32'(frame_of(p)), "mapped frame");
      check("R2", 32'(phys_addr[11:0]), 32'(log_addr[11:0]), "offset while on");
    end
  endtask

  task automatic t_readback();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      reg_read(1'b0, i, v);
      check("R7", 32'(v), 32'(frame_of(i)), "entry readback");
    end
  endtask

  task automatic t_same_cycle();
    // table write to the page being translated
    @(negedge clk);
    log_addr = 16'h5ABC;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 4'd5; cfg_wdata = 8'h77;
    #1 check("R6", 32'(phys_addr), {12'h0, frame_of(5), 12'hABC}, "old frame in strobe cycle");
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R6", 32'(phys_addr), 32'h77ABC, "new frame next cycle");
    check("R7", 32'(cfg_rdata), 32'(frame_of(5)), "read-first during write");
    reg_write(1'b0, 5, frame_of(5));
    // control write while a translated page is addressed
    @(negedge clk);
    log_addr = 16'h2010;
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h00;
    #1 check("R6", 32'(phys_addr[19:12]), 32'(frame_of(2)), "still mapped in disable strobe");
    @(negedge clk);
    cfg_we = 1'b0;
    #1 check("R6", 32'(phys_addr[19:12]), 32'hFF, "top frame after disable");
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h01;
    #1 check("R6", 32'(phys_addr[19:12]), 32'hFF, "still off in enable strobe");
    @(negedge clk);
    cfg_we = 1'b0;
    #1 check("R6", 32'(phys_addr[19:12]), 32'(frame_of(2)), "mapped after enable");
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] v;
    reg_write(1'b1, 0, 8'hFE);
    #1 check("R4", 32'(xlate_on), 32'd0, "bit0 clear disables");
    reg_read(1'b1, 0, v);
    check("R7", 32'(v), 32'h00, "control read when off");
    reg_write(1'b1, 0, 8'hFF);
    #1 check("R4", 32'(xlate_on), 32'd1, "bit0 set enables");
    reg_read(1'b1, 0, v);
    check("R4", 32'(v), 32'h01, "upper control bits ignored");
  endtask

  task automatic t_off_keeps();
    logic [7:0] v;
    reg_write(1'b1, 0, 8'h00);
    t_off_sweep();
    reg_read(1'b0, 9, v);
    check("R8", 32'(v), 32'(frame_of(9)), "entry kept while off");
    reg_write(1'b1, 0, 8'h01);
    t_map_sweep("R8");
  endtask

  initial begin
    t_reset();
    t_off_sweep();
    t_load_and_enable();
    t_map_sweep("R5");
    t_readback();
    t_same_cycle();
    t_ctrl_bits();
    t_off_keeps();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule